// File: doc/BRIEF.md
# Framed Serial Conversion Result Transmitter

This block ships one 14-bit conversion result per conversion cycle as a framed 16-bit serial word over three open-drain lines: an active-low frame strobe, a serial clock and a data line. A rising edge on the conversion-start input opens a cycle. A behavioural converter stub supplies the result on a parallel bus together with a ready flag. The word starts with two zero pad bits, so the result has two bit periods to arrive before its most significant bit goes out.

Each line is modelled as a pull-down enable: 1 pulls the line low and 0 releases it to its pull-up. The block never drives a line high. The serial clock comes from the system clock through a parameterised divider. A mode input picks the clock behaviour. In gated mode the clock runs only while a frame is open and is released between frames. In free-running mode it toggles all the time, and a frame waits for its next rising edge before it opens.

Top module: `sres_tx`

## Requirements
- R1: In gated mode, the frame line is pulled low on the cycle after the start rising edge is sampled. In free-running mode, the frame opens on the next rising serial clock edge, no more than 2*HALF_DIV cycles later.
- R2: Each word has 16 bits. Bits 0 and 1 are zero pads, and bits 2 to 15 carry the result, most significant bit first. The first pad bit is on the data line when the frame opens.
- R3: While a frame is open, the data line changes only when the serial clock rises. A receiver samples on falling edges.
- R4: One serial clock period is 2*HALF_DIV system cycles, with the high half first, and each bit lasts one period. The frame opens with the clock high. It stays low for exactly 32*HALF_DIV cycles and is released at the rising edge that follows the 16th falling edge.
- R5: In gated mode the clock line is released whenever no frame is open. In free-running mode it toggles continuously, frames or not.
- R6: The result is latched when the ready flag is high during the wait for the frame or during the two pad bit periods. A ready flag after that is ignored. With no ready flag in that window, the result bits are all zero.
- R7: A start rising edge that arrives while a conversion is waiting or its frame is open is ignored. The frame keeps its length and no extra frame follows.
- R8: Every output is a pull-down enable (1 = line low). The data line is pulled low only for 0 bits inside a frame, and the frame and data lines are released when idle.
- R9: During and right after reset, all three lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| conv_start_i | input | 1 | Conversion start; a rising edge begins a cycle |
| free_clk_i | input | 1 | 1 = free-running serial clock, 0 = gated |
| res_ready_i | input | 1 | Result-ready flag from the converter stub |
| res_data_i | input | RES_W | Parallel conversion result |
| frame_pd_o | output | 1 | Frame strobe pull-down (1 = frame open) |
| sclk_pd_o | output | 1 | Serial clock pull-down (1 = clock low) |
| sdata_pd_o | output | 1 | Data pull-down (1 = bit 0 on the line) |

## Verification
The hardest case is the edge of the result-capture window. A ready flag must land in the last system cycle of the second pad bit to be taken, while one that lands in the first result bit must be dropped. The bench measures every delay from the cycle in which it sees the frame open. It places the ready flag at random offsets across the whole window, including the last legal cycle, and sends a second, different value after the window closes. A built-in receiver rebuilds each word from falling clock edges. A restart edge is sent inside an open frame to show that the frame length does not change and no extra frame follows.

// File: rtl/sres_tx_pkg.sv
package sres_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sres_start_edge.sv
module sres_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sres_sclk_gen.sv
module sres_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_hi_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            hi;
    } gen_t;

    gen_t gen_d, gen_q;
    logic tick;

    assign tick = (gen_q.ph == PH_W'(HALF_DIV - 1));

    always_comb begin
        gen_d = gen_q;
        if (!run_i) begin
            gen_d.ph = '0;
            gen_d.hi = 1'b1;
        end else if (tick) begin
            gen_d.ph = '0;
            gen_d.hi = ~gen_q.hi;
        end else begin
            gen_d.ph = gen_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '{ph: '0, hi: 1'b1};
        else        gen_q <= gen_d;
    end

    assign sclk_hi_o = gen_q.hi;
    assign rise_o    = run_i & tick & ~gen_q.hi;
    assign fall_o    = run_i & tick & gen_q.hi;
endmodule

// File: rtl/sres_bit_sel.sv
module sres_bit_sel #(
    parameter int RES_W = 14,
    parameter int PAD_W = 2
) (
    input  logic [$clog2(RES_W+PAD_W)-1:0] idx_i,
    input  logic [RES_W-1:0]               res_i,
    output logic                           bit_o
);
    localparam int IDX_W = $clog2(RES_W + PAD_W);

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < RES_W; i++) begin
            if (idx_i == IDX_W'(PAD_W + i)) bit_o = res_i[RES_W-1-i];
        end
    end
endmodule

// File: rtl/sres_tx.sv
module sres_tx
    import sres_tx_pkg::*;
#(
    parameter int RES_W    = 14,
    parameter int PAD_W    = 2,
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic             free_clk_i,
    input  logic             res_ready_i,
    input  logic [RES_W-1:0] res_data_i,
    output logic             frame_pd_o,
    output logic             sclk_pd_o,
    output logic             sdata_pd_o
);
    localparam int WORD_W = RES_W + PAD_W;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] res;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_rise, sclk_hi, sclk_rise, sclk_fall, run, cur_bit;
    logic accept, capture;

    sres_start_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (conv_start_i),
        .rise_o(start_rise)
    );

    assign run = free_clk_i | (ctl_q.st != ST_IDLE);

    sres_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .sclk_hi_o(sclk_hi),
        .rise_o   (sclk_rise),
        .fall_o   (sclk_fall)
    );

    sres_bit_sel #(.RES_W(RES_W), .PAD_W(PAD_W)) u_sel (
        .idx_i(ctl_q.idx),
        .res_i(ctl_q.res),
        .bit_o(cur_bit)
    );

    always_comb begin
        ctl_d   = ctl_q;
        accept  = start_rise & (ctl_q.st == ST_IDLE);
        capture = res_ready_i & (ctl_q.st != ST_IDLE)
                & (ctl_q.idx < IDX_W'(PAD_W));
        if (capture) ctl_d.res = res_data_i;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.res = '0;
                    ctl_d.idx = '0;
                    ctl_d.st  = (!free_clk_i || sclk_rise) ? ST_SEND : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sclk_rise) ctl_d.st = ST_SEND;
            end
            ST_SEND: begin
                if (sclk_rise) begin
                    if (ctl_q.idx == IDX_W'(WORD_W - 1)) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, idx: '0, res: '0};
        else        ctl_q <= ctl_d;
    end

    assign frame_pd_o = (ctl_q.st == ST_SEND);
    assign sdata_pd_o = frame_pd_o & ~cur_bit;
    assign sclk_pd_o  = ~sclk_hi;

    logic unused_fall;
    assign unused_fall = sclk_fall;
endmodule

// File: rtl/sres_tx_chk.sv
module sres_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic free_clk_i,
    input logic frame_pd_o,
    input logic sclk_pd_o,
    input logic sdata_pd_o
);
    // R8
    data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_pd_o |-> frame_pd_o);

    // R5
    gated_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_clk_i && $past(!free_clk_i) && !frame_pd_o) |-> !sclk_pd_o);

    // R4
    open_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pd_o) |-> !sclk_pd_o);

    // R3
    data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pd_o && $past(frame_pd_o) && (sdata_pd_o != $past(sdata_pd_o)))
            |-> $fell(sclk_pd_o));

    // R2
    pad_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pd_o) |-> sdata_pd_o);
endmodule

bind sres_tx sres_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_clk_i(free_clk_i),
    .frame_pd_o(frame_pd_o),
    .sclk_pd_o (sclk_pd_o),
    .sdata_pd_o(sdata_pd_o)
);

// File: tb/sres_tx_bench.sv
`timescale 1ns/1ps
module sres_tx_bench;
    localparam int HALF = 2;
    localparam int RW   = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 1'b0, free_clk = 1'b0, res_ready = 1'b0;
    logic [RW-1:0] res_data = '0;
    logic frame_pd, sclk_pd, sdata_pd;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sres_tx #(.RES_W(RW), .PAD_W(2), .HALF_DIV(HALF)) u_sres_tx (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start),
        .free_clk_i(free_clk), .res_ready_i(res_ready), .res_data_i(res_data),
        .frame_pd_o(frame_pd), .sclk_pd_o(sclk_pd), .sdata_pd_o(sdata_pd)
    );

    // receiver model: rebuilds the word on falling serial clock edges
    logic [15:0] rx_word = '0;
    int falls = 0, flen = 0, stab_err = 0;
    logic fprev = 1'b0, sprev = 1'b1, dprev = 1'b0;
    always @(negedge clk) begin
        logic lvl;
        lvl = ~sclk_pd;
        if (rst_n && frame_pd) begin
            if (!fprev) begin falls = 0; flen = 0; rx_word = '0; end
            flen++;
            if (fprev && sprev && !lvl) begin
                rx_word = {rx_word[14:0], ~sdata_pd};
                falls++;
            end
            if (fprev && (sdata_pd != dprev) && !(!sprev && lvl)) stab_err++;
        end
        fprev = frame_pd; sprev = lvl; dprev = sdata_pd;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_word(input logic [RW-1:0] v, input bit got);
        return got ? {2'b00, v} : 16'h0000;
    endfunction

    // rdy_dly < 0: no ready flag in the window
    task automatic do_frame(input bit mode, input logic [RW-1:0] val, input int rdy_dly,
                            input bit late, input bit extra);
        int lat, used, wait_n, toggles;
        logic s0;
        free_clk = mode;
        cyc(3);
        conv_start = 1'b1;
        cyc(1);
        lat = 0;
        while (!frame_pd && lat < 20) begin lat++; cyc(1); end
        if (!mode) check(lat == 0, "R1 gated open latency", lat, 0);
        else       check(lat <= 2*HALF, "R1 free open latency", lat, 2*HALF);
        used = 0;
        if (rdy_dly >= 0) begin
            cyc(rdy_dly);
            res_ready = 1'b1; res_data = val;
            cyc(1);
            res_ready = 1'b0; res_data = RW'($urandom);
            used = rdy_dly + 1;
        end
        conv_start = 1'b0;
        if (late) begin
            if (used < 4*HALF + 2) cyc(4*HALF + 2 - used);
            res_ready = 1'b1; res_data = ~val;
            cyc(1);
            res_ready = 1'b0;
            used = 4*HALF + 3;
        end
        if (extra) begin
            cyc(3); conv_start = 1'b1; cyc(2); conv_start = 1'b0;
        end
        wait_n = 0;
        while (frame_pd && wait_n < 200) begin wait_n++; cyc(1); end
        check(rx_word == exp_word(val, rdy_dly >= 0), "R2/R6 received word",
              int'(rx_word), int'(exp_word(val, rdy_dly >= 0)));
        check(falls == 16, "R3 falling edges per frame", falls, 16);
        check(flen == 32*HALF, "R4 frame length", flen, 32*HALF);
        toggles = 0;
        s0 = sclk_pd;
        for (int i = 0; i < 6*HALF; i++) begin
            cyc(1);
            if (sclk_pd != s0) toggles++;
            s0 = sclk_pd;
            if (frame_pd || sdata_pd) begin
                check(1'b0, extra ? "R7 no frame after ignored start" : "R8 idle lines",
                      int'({frame_pd, sdata_pd}), 0);
                break;
            end
        end
        if (!mode) check(toggles == 0 && !sclk_pd, "R5 gated clock released", toggles, 0);
        else       check(toggles >= 2, "R5 free clock toggles", toggles, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        check(!frame_pd, "R9 reset frame", frame_pd, 0);
        check(!sclk_pd, "R9 reset clock", sclk_pd, 0);
        check(!sdata_pd, "R9 reset data", sdata_pd, 0);
        rst_n = 1'b1;
        cyc(2);
        check(!frame_pd && !sclk_pd && !sdata_pd, "R9 after reset",
              int'({frame_pd, sclk_pd, sdata_pd}), 0);
        // directed corners
        do_frame(1'b0, 14'h3FFF, 0, 1'b0, 1'b0);          // R2 all ones
        do_frame(1'b0, 14'h0001, 4*HALF - 1, 1'b0, 1'b0); // R6 last legal ready cycle
        do_frame(1'b1, 14'h2AAA, 3, 1'b0, 1'b0);          // R1 free mode
        res_ready = 1'b1; res_data = 14'h1234; cyc(1); res_ready = 1'b0;
        do_frame(1'b0, 14'h1234, -1, 1'b0, 1'b0);         // R6 idle ready ignored, zeros
        do_frame(1'b0, 14'h0F0F, 2, 1'b1, 1'b0);          // R6 late ready ignored
        do_frame(1'b0, 14'h1555, 1, 1'b0, 1'b1);          // R7 restart in frame
        do_frame(1'b1, 14'h3C3C, 5, 1'b1, 1'b1);          // R7 free mode
        for (int k = 0; k < 40; k++) begin
            do_frame(1'($urandom), RW'($urandom), int'($urandom % (4*HALF)),
                     1'($urandom), 1'($urandom));
        end
        check(stab_err == 0, "R3 data stable except at clock rise", stab_err, 0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule